// File: doc/BRIEF.md
# Programmable interrupt routing matrix

This block steers 128 device interrupt lines onto 24 output lines that feed a downstream interrupt controller. Each input has its own configuration register. That register holds an enable flag and the number of the output the input should drive. Routing is purely combinational. No edge is captured and no request is held pending. An output shows, at every moment, the OR of the present levels of every enabled input steered to it. A short pulse on an input is therefore seen on its output only while the pulse lasts.

Software programs the matrix through a small word-addressed register port. A four-word read-only window exposes the raw level of every input, whether or not that input is enabled. Reads are returned one cycle after they are requested, and the returned value holds until the next read.

Top module: `irq_route_matrix`

## Requirements
- R1: After reset every configuration register reads zero, every output is low whatever the inputs do, and the read data is zero.
- R2: An enabled input whose output number is below 24 drives that output with its current level. The output follows a one-cycle pulse during that cycle only, with no latching.
- R3: When several enabled inputs select the same output, the output is the OR of their levels.
- R4: An enabled input whose output number is 24 to 31 drives no output.
- R5: An input whose bit 31 is clear drives nothing. Writing zero to an input's register disables it.
- R6: The register of input i sits at byte address 4*i, and address bits 1:0 are ignored. Bit 31 is the enable and bits 4:0 are the output number. Bits 30:5 read as zero and ignore writes.
- R7: Byte addresses 0x420, 0x424, 0x428 and 0x42C read the raw input levels, with input 32*k+j at bit j of word k. The levels are sampled at the clock edge that accepts the read, and the window shows every input regardless of its enable.
- R8: Writes to the status window or to any address that maps to no register change nothing. Reads of such unmapped addresses return zero.
- R9: Read data appears in the cycle after reg_rd is sampled high and holds until the next read. A configuration write changes routing from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Byte address of the access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq_in | input | 128 | Device interrupt levels |
| irq_out | output | 24 | Routed interrupt lines |

## Verification
Two things can land in the same cycle: a configuration write that re-steers an input while that input is toggling, and a status-window read taken just as input levels change. The bench drives fresh random input levels every cycle and mixes random writes, configuration reads and status reads into that stream. A behavioural model updates its routing table at the write edge and captures input levels at the read edge. The outputs and read data are compared against this model on every clock, so a routing change that arrives a cycle early or late is caught. So is a status word sampled from the wrong cycle.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int unsigned SEL_W = 5;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } route_cfg_t;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned           N_IN      = 128,
    parameter int unsigned           DATA_W    = 32,
    parameter int unsigned           ADDR_W    = 12,
    parameter logic [ADDR_W-1:0]     STAT_BASE = 12'h420
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic [DATA_W-1:0]         reg_wdata,
    input  logic                      reg_rd,
    output logic [DATA_W-1:0]         reg_rdata,
    input  logic [N_IN-1:0]           irq_in,
    output route_cfg_t [N_IN-1:0]     cfg_o
);
    localparam int unsigned IDX_W      = ADDR_W - 2;
    localparam int unsigned CFG_IDX_W  = $clog2(N_IN);
    localparam int unsigned STAT_WORDS = N_IN / DATA_W;
    localparam int unsigned STAT_OFF_W = (STAT_WORDS > 1) ? $clog2(STAT_WORDS) : 1;
    localparam logic [IDX_W-1:0] STAT_IDX = STAT_BASE[ADDR_W-1:2];
    localparam logic [IDX_W-1:0] STAT_END = STAT_IDX + IDX_W'(STAT_WORDS);
    localparam logic [IDX_W-1:0] CFG_END  = IDX_W'(N_IN);

    typedef struct packed {
        route_cfg_t [N_IN-1:0] cfg;
        logic [DATA_W-1:0]     rdata;
    } regs_state_t;

    regs_state_t state_d, state_q;

    logic [IDX_W-1:0]      word;
    logic [IDX_W-1:0]      stat_rel;
    logic [CFG_IDX_W-1:0]  cfg_idx;
    logic [STAT_OFF_W-1:0] stat_off;
    logic                  cfg_hit, stat_hit;
    logic [DATA_W-1:0]     rd_val;

    always_comb begin
        state_d  = state_q;
        word     = reg_addr[ADDR_W-1:2];
        cfg_idx  = word[CFG_IDX_W-1:0];
        stat_rel = word - STAT_IDX;
        stat_off = stat_rel[STAT_OFF_W-1:0];
        cfg_hit  = (word < CFG_END);
        stat_hit = (word >= STAT_IDX) && (word < STAT_END);
        rd_val   = '0;

        if (cfg_hit) begin
            rd_val[DATA_W-1]  = state_q.cfg[cfg_idx].en;
            rd_val[SEL_W-1:0] = state_q.cfg[cfg_idx].sel;
        end else if (stat_hit) begin
            for (int k = 0; k < STAT_WORDS; k++) begin
                if (stat_off == STAT_OFF_W'(k)) begin
                    rd_val = irq_in[k*DATA_W +: DATA_W];
                end
            end
        end

        if (reg_wr && cfg_hit) begin
            state_d.cfg[cfg_idx].en  = reg_wdata[DATA_W-1];
            state_d.cfg[cfg_idx].sel = reg_wdata[SEL_W-1:0];
        end

        if (reg_rd) begin
            state_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_rdata = state_q.rdata;
    assign cfg_o     = state_q.cfg;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R9

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(cfg_o)); // R8

    AST_PAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && cfg_hit) |=> (reg_rdata[DATA_W-2:SEL_W] == '0)); // R6

    AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !cfg_hit && !stat_hit) |=> (reg_rdata == '0)); // R8

    AST_STAT_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (word == STAT_IDX)) |=> (reg_rdata == $past(irq_in[DATA_W-1:0]))); // R7
endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
    import irq_route_pkg::*;
#(
    parameter int unsigned N_IN  = 128,
    parameter int unsigned N_OUT = 24
) (
    input  logic [N_IN-1:0]       irq_in,
    input  route_cfg_t [N_IN-1:0] cfg,
    output logic [N_OUT-1:0]      irq_out
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [N_IN-1:0] hit;

        always_comb begin
            for (int i = 0; i < N_IN; i++) begin
                hit[i] = cfg[i].en && (cfg[i].sel == SEL_W'(o)) && irq_in[i];
            end
        end

        assign irq_out[o] = |hit;
    end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
    import irq_route_pkg::*;
#(
    parameter int unsigned       N_IN      = 128,
    parameter int unsigned       N_OUT     = 24,
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] STAT_BASE = 12'h420
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_IN-1:0]   irq_in,
    output logic [N_OUT-1:0]  irq_out
);
    route_cfg_t [N_IN-1:0] route_cfg;

    irq_route_regs #(
        .N_IN      (N_IN),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .STAT_BASE (STAT_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .irq_in    (irq_in),
        .cfg_o     (route_cfg)
    );

    irq_route_xbar #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT)
    ) u_xbar (
        .irq_in  (irq_in),
        .cfg     (route_cfg),
        .irq_out (irq_out)
    );

    logic any_en;
    always_comb begin
        any_en = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            any_en = any_en | route_cfg[i].en;
        end
    end

    AST_QUIET_IN_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in == '0) |-> (irq_out == '0)); // R2

    AST_NONE_ENABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |-> (irq_out == '0)); // R5

    AST_RESET_OUT_LOW: assert property (@(posedge clk)
        $past(!rst_n) |-> (irq_out == '0)); // R1
endmodule

// File: tb/irq_route_matrix_tb_top.sv
module irq_route_matrix_tb_top;
    localparam int N_IN  = 128;
    localparam int N_OUT = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic         reg_rd = 1'b0;
    logic [31:0]  reg_rdata;
    logic [127:0] irq_in = '0;
    logic [23:0]  irq_out;

    always #4 clk = ~clk;

    irq_route_matrix dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .irq_in    (irq_in),
        .irq_out   (irq_out)
    );

    bit          m_en  [N_IN];
    bit [4:0]    m_sel [N_IN];
    logic [31:0] m_rdata = '0;
    int          vecs = 0;
    int          fails = 0;
    string       req = "R1";
    bit          finished = 1'b0;

    function automatic logic [23:0] exp_out();
        logic [23:0] r = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (m_en[i] && m_sel[i] < 5'd24 && irq_in[i]) r[m_sel[i]] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        int w = int'(a[11:2]);
        if (w < N_IN) return {m_en[w], 26'd0, m_sel[w]};
        if (w >= 'h108 && w <= 'h10B) return irq_in[(w - 'h108)*32 +: 32];
        return 32'd0;
    endfunction

    task automatic check();
        logic [23:0] eo = exp_out();
        vecs++;
        if (irq_out !== eo) begin
            fails++;
            $display("FAIL %s: irq_out=%h expected %h", req, irq_out, eo);
        end
        vecs++;
        if (reg_rdata !== m_rdata) begin
            fails++;
            $display("FAIL %s: reg_rdata=%h expected %h", req, reg_rdata, m_rdata);
        end
    endtask

    task automatic step(bit wr, bit rd, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        #2;
        check();
        @(posedge clk);
        if (rst_n) begin
            if (rd) m_rdata = exp_read(a);
            if (wr && a[11:2] < 10'd128) begin
                m_en[a[8:2]]  = d[31];
                m_sel[a[8:2]] = d[4:0];
            end
        end
        #1;
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 12'h0, 32'h0);
    endtask

    task automatic wr_cfg(int i, logic [31:0] d);
        step(1, 0, 12'(i*4), d);
    endtask

    task automatic rd_addr(logic [11:0] a);
        step(0, 1, a, 32'h0);
        idle(1);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state with inputs all high
        req = "R1";
        irq_in = '1;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        rd_addr(12'h014);

        // R6: field layout and pad bits, low address bits ignored
        req = "R6";
        wr_cfg(5, 32'hFFFF_FFE3);
        rd_addr(12'h014);
        step(1, 0, 12'h01B, 32'h8000_0009);
        rd_addr(12'h018);

        // R2: level follow and one-cycle pulse
        req = "R2";
        irq_in = '0;
        idle(1);
        irq_in[5] = 1'b1;
        idle(1);
        irq_in[5] = 1'b0;
        idle(2);
        irq_in[6] = 1'b1;
        idle(2);

        // R3: OR of several inputs on one output
        req = "R3";
        irq_in = '0;
        wr_cfg(70, 32'h8000_0003);
        wr_cfg(127, 32'h8000_0003);
        irq_in[70] = 1'b1;
        idle(1);
        irq_in[70] = 1'b0; irq_in[127] = 1'b1;
        idle(1);
        irq_in[5] = 1'b1; irq_in[70] = 1'b1;
        idle(1);
        irq_in = '0;
        idle(1);

        // R4: out-of-range output numbers
        req = "R4";
        wr_cfg(10, 32'h8000_0018);
        wr_cfg(11, 32'h8000_001F);
        irq_in[10] = 1'b1; irq_in[11] = 1'b1;
        idle(2);
        rd_addr(12'h028);

        // R5: disable via zero and via clear enable
        req = "R5";
        irq_in = '1;
        idle(1);
        wr_cfg(5, 32'h0);
        wr_cfg(70, 32'h0000_0007);
        idle(2);
        rd_addr(12'h118);

        // R7: status window, independent of enables
        req = "R7";
        irq_in = {32'hDEAD_BEEF, 32'h0123_4567, 32'h8000_0001, 32'hA5A5_5A5A};
        rd_addr(12'h420);
        rd_addr(12'h424);
        rd_addr(12'h428);
        rd_addr(12'h42C);

        // R8: ignored writes, unmapped reads
        req = "R8";
        step(1, 0, 12'h420, 32'h8000_0001);
        step(1, 0, 12'h200, 32'h8000_0002);
        step(1, 0, 12'hFFC, 32'h8000_0004);
        rd_addr(12'h200);
        rd_addr(12'h41C);
        rd_addr(12'h430);
        rd_addr(12'h000);
        rd_addr(12'h420);

        // R9: mixed traffic with routing changes and status reads
        req = "R9";
        for (int n = 0; n < 600; n++) begin
            int op = int'($urandom_range(0, 3));
            irq_in = {$urandom, $urandom, $urandom, $urandom};
            case (op)
                0: step(1, 0, {3'd0, 7'($urandom_range(0, 127)), 2'($urandom)}, $urandom);
                1: step(0, 1, {3'd0, 7'($urandom_range(0, 127)), 2'($urandom)}, 32'h0);
                2: step(0, 1, 12'h420 + 12'(4 * $urandom_range(0, 3)), 32'h0);
                default: step(0, 0, 12'h0, 32'h0);
            endcase
        end
        idle(2);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule